// File: doc/BRIEF.md
# Isolated Digital I/O Controller with Change-of-State Interrupts

This block is the register-level core of a 56-line digital I/O card. Lines 0–23 are outputs only. Lines 24–47 are inputs only. Lines 48–55 form one 8-bit bank whose direction software selects. A host reaches all of it through a 16-byte window, organised as four 32-bit words. Every byte lane can be written on its own through byte enables, and a word read returns four bytes at once, so software can fetch all change-of-state status in one access.

Each input-capable byte (three input bytes and the switchable bank) passes through a synchroniser. It then feeds an edge detector that has one enable for rising transitions and one for falling transitions. Detected edges are latched into status bytes that software clears by writing ones. A single level-sensitive interrupt stays high while any status bit is set. A write to the last byte of the window returns the outputs, the control, the enables and the status to their power-up values.

Top module: `dio_cos_ctrl`

## Requirements
- R1: Byte offsets 0, 1 and 2 drive `out_o` lines 0–7, 8–15 and 16–23. They read back the last value written, starting the cycle after the write.
- R2: Byte 3 is the latch for the switchable bank. Bit 1 of the control byte (offset 12) sets `bidir_oe_o`. `bidir_o` shows the latch only while that bit is 1 and is 0 otherwise, even after the latch has been written.
- R3: Bytes 4–6 return `in_i` after a two-register synchroniser, so a pin change is readable after the second rising clock edge. Byte 7 returns the byte-3 latch when control bit 1 is set, and the synchronised `bidir_i` otherwise.
- R4: In the enable byte (offset 14), bit n enables rising edges and bit n+4 enables falling edges for bank n. Banks 0–2 are input bytes 4–6 and bank 3 is `bidir_i`. An enabled edge sets the matching status bit at the third rising clock edge after the pin change.
- R5: A transition whose edge enable is clear leaves every status bit unchanged.
- R6: Writing to status bytes 8–11 clears each bit written as 1. Bits written as 0 are left as they are.
- R7: If an enabled edge and a clear of the same status bit fall in the same cycle, the bit stays set.
- R8: `irq_o` is high exactly while any status bit is set. It goes low in the cycle after the write that clears the last set bit.
- R9: A word read at word address 2 returns status bytes 8–11, with byte 8 in bits 7:0. Only lanes whose `bus_be_i` bit is set are written.
- R10: Any write to byte 15 clears the output latches, the control byte, the enables and the status. Bytes 13 and 15 always read 0.
- R11: After `rst_ni` is released, all outputs and all readable bytes are 0 while the inputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for the addressed word |
| bus_addr_i | input | 2 | Word address inside the 16-byte window |
| bus_be_i | input | 4 | Byte-lane enables for writes |
| bus_wdata_i | input | 32 | Write data; lane k carries byte 4*addr+k |
| bus_rdata_o | output | 32 | Read data of the addressed word (combinational) |
| out_o | output | 24 | Output-only lines 0–23 |
| in_i | input | 24 | Input-only lines 24–47 |
| bidir_i | input | 8 | Pin levels of the switchable bank |
| bidir_o | output | 8 | Drive values of the switchable bank |
| bidir_oe_o | output | 1 | Drive enable of the switchable bank |
| irq_o | output | 1 | Level interrupt, high while status is pending |

## Verification
A wrong synchroniser depth or edge sampler shows up as a status bit that appears one cycle early or late, or a readback of an input byte that is off by one cycle. The cycle-by-cycle comparison catches this on the very cycle it happens. A wrong enable polarity or clear-versus-edge priority leaves a stale or missing bit in the status word, and `irq_o` then diverges at once. A latch or control bit corrupted by a partial-lane write, or left over after a soft reset, appears on `out_o`, `bidir_o` or the readback in the cycle after the write.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned LANES       = 4;
  localparam int unsigned WORD_AW     = 2;
  localparam int unsigned N_WIN_BYTES = LANES * (1 << WORD_AW);
  localparam int unsigned N_OUT_BYTES = 3;
  localparam int unsigned N_IN_BYTES  = 3;
  localparam int unsigned N_COS_BANKS = N_IN_BYTES + 1;

  // window layout (software-visible)
  localparam int unsigned OFS_OUT      = 0;
  localparam int unsigned OFS_IN       = OFS_OUT + N_OUT_BYTES + 1;
  localparam int unsigned OFS_BIDIR_IN = OFS_IN + N_IN_BYTES;
  localparam int unsigned OFS_COS      = OFS_BIDIR_IN + 1;
  localparam int unsigned OFS_CTL      = OFS_COS + N_COS_BANKS;
  localparam int unsigned OFS_COS_EN   = OFS_CTL + 2;
  localparam int unsigned OFS_SRST     = OFS_COS_EN + 1;

  localparam int unsigned CTL_DIR_BIT = 1;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign q_o      = stg_q[STAGES-1];
  assign q_prev_o = prev_q;
endmodule

// File: rtl/dio_cos_bank.sv
module dio_cos_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic         rise_en_i,
  input  logic         fall_en_i,
  input  logic [W-1:0] clr_i,
  input  logic         srst_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] rise_w, fall_w, set_w, st_q;

  assign rise_w = cur_i & ~prev_i;
  assign fall_w = ~cur_i & prev_i;
  assign set_w  = (rise_en_i ? rise_w : '0) | (fall_en_i ? fall_w : '0);

  // new edge beats a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= '0;
    else if (srst_i) st_q <= '0;
    else             st_q <= (st_q & ~clr_i) | set_w;
  end

  assign status_o = st_q;

  AST_NO_SET_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_en_i && !fall_en_i) |=> ((status_o & ~$past(status_o)) == '0)); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_w)) |=> ((status_o & $past(clr_i & ~set_w)) == '0)); // R6
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|set_w) && !srst_i) |=> ((status_o & $past(set_w)) == $past(set_w))); // R7
endmodule

// File: rtl/dio_cos_ctrl.sv
module dio_cos_ctrl
  import dio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_we_i,
  input  logic [WORD_AW-1:0]          bus_addr_i,
  input  logic [LANES-1:0]            bus_be_i,
  input  logic [LANES*BYTE_W-1:0]     bus_wdata_i,
  output logic [LANES*BYTE_W-1:0]     bus_rdata_o,
  output logic [N_OUT_BYTES*BYTE_W-1:0] out_o,
  input  logic [N_IN_BYTES*BYTE_W-1:0]  in_i,
  input  logic [BYTE_W-1:0]           bidir_i,
  output logic [BYTE_W-1:0]           bidir_o,
  output logic                        bidir_oe_o,
  output logic                        irq_o
);
  localparam int unsigned IN_W  = N_IN_BYTES * BYTE_W;
  localparam int unsigned PIN_W = N_COS_BANKS * BYTE_W;
  localparam int unsigned N_LAT = N_OUT_BYTES + 1;

  // byte write decode
  logic [N_WIN_BYTES-1:0] bwr;
  byte_t                  bwd [N_WIN_BYTES];

  always_comb begin
    for (int b = 0; b < N_WIN_BYTES; b++) begin
      bwr[b] = bus_we_i && (int'(bus_addr_i) == b / LANES) && bus_be_i[b % LANES];
      bwd[b] = bus_wdata_i[BYTE_W*(b % LANES) +: BYTE_W];
    end
  end

  logic srst;
  assign srst = bwr[OFS_SRST];

  // output latches, control, enables
  byte_t out_q [N_LAT];
  byte_t ctl_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_LAT; i++) out_q[i] <= '0;
      ctl_q <= '0;
      en_q  <= '0;
    end else if (srst) begin
      for (int i = 0; i < N_LAT; i++) out_q[i] <= '0;
      ctl_q <= '0;
      en_q  <= '0;
    end else begin
      for (int i = 0; i < N_LAT; i++)
        if (bwr[OFS_OUT+i]) out_q[i] <= bwd[OFS_OUT+i];
      if (bwr[OFS_CTL])    ctl_q <= bwd[OFS_CTL];
      if (bwr[OFS_COS_EN]) en_q  <= bwd[OFS_COS_EN];
    end
  end

  for (genvar g = 0; g < N_OUT_BYTES; g++) begin : g_out
    assign out_o[g*BYTE_W +: BYTE_W] = out_q[g];
  end

  assign bidir_oe_o = ctl_q[CTL_DIR_BIT];
  assign bidir_o    = bidir_oe_o ? out_q[N_OUT_BYTES] : '0;

  // input synchronisation
  logic [PIN_W-1:0] pin_s, pin_p;

  dio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      ({bidir_i, in_i}),
    .q_o      (pin_s),
    .q_prev_o (pin_p)
  );

  // change-of-state banks
  byte_t            cos_st  [N_COS_BANKS];
  byte_t            cos_clr [N_COS_BANKS];
  logic [PIN_W-1:0] cos_flat;

  for (genvar g = 0; g < N_COS_BANKS; g++) begin : g_cos
    assign cos_clr[g] = bwr[OFS_COS+g] ? bwd[OFS_COS+g] : '0;

    dio_cos_bank #(.W(BYTE_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cur_i     (pin_s[g*BYTE_W +: BYTE_W]),
      .prev_i    (pin_p[g*BYTE_W +: BYTE_W]),
      .rise_en_i (en_q[g]),
      .fall_en_i (en_q[g+N_COS_BANKS]),
      .clr_i     (cos_clr[g]),
      .srst_i    (srst),
      .status_o  (cos_st[g])
    );

    assign cos_flat[g*BYTE_W +: BYTE_W] = cos_st[g];
  end

  assign irq_o = |cos_flat;

  // read mux
  byte_t rd [N_WIN_BYTES];

  always_comb begin
    for (int b = 0; b < N_WIN_BYTES; b++) rd[b] = '0;
    for (int i = 0; i < N_LAT; i++) rd[OFS_OUT+i] = out_q[i];
    for (int i = 0; i < N_IN_BYTES; i++) rd[OFS_IN+i] = pin_s[i*BYTE_W +: BYTE_W];
    rd[OFS_BIDIR_IN] = bidir_oe_o ? out_q[N_OUT_BYTES] : pin_s[IN_W +: BYTE_W];
    for (int i = 0; i < N_COS_BANKS; i++) rd[OFS_COS+i] = cos_st[i];
    rd[OFS_CTL]    = ctl_q;
    rd[OFS_COS_EN] = en_q;
  end

  always_comb begin
    for (int l = 0; l < LANES; l++)
      bus_rdata_o[l*BYTE_W +: BYTE_W] = rd[int'(bus_addr_i)*LANES + l];
  end

  AST_SRST_CLEARS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (out_o == '0 && !bidir_oe_o && !irq_o)); // R10
  AST_IRQ_FALLS_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(bus_we_i)); // R8
  AST_PINS_QUIET_AS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(srst) |-> (bidir_o == '0)); // R2
endmodule

// File: tb/sim_dio_cos_ctrl.sv
module sim_dio_cos_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [23:0] out_w;
  logic [23:0] pin_in = '0;
  logic [7:0]  pin_bd = '0;
  logic [7:0]  bd_o;
  logic        bd_oe, irq;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dio_cos_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr), .bus_be_i(be),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .out_o(out_w), .in_i(pin_in),
    .bidir_i(pin_bd), .bidir_o(bd_o), .bidir_oe_o(bd_oe), .irq_o(irq)
  );

  // behavioural reference model
  logic [7:0]  m_out [4];
  logic [7:0]  m_st  [4];
  logic [7:0]  m_ctl, m_en;
  logic [31:0] m_p1, m_p2, m_p3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_out[i] = 0; m_st[i] = 0; end
      m_ctl = 0; m_en = 0; m_p1 = 0; m_p2 = 0; m_p3 = 0;
    end else begin
      logic [31:0] rise, fall;
      logic [7:0]  wb [16];
      bit          wr [16];
      for (int b = 0; b < 16; b++) begin
        wr[b] = we && (addr == b / 4) && be[b % 4];
        wb[b] = wdata[8*(b % 4) +: 8];
      end
      rise = m_p2 & ~m_p3;
      fall = ~m_p2 & m_p3;
      if (wr[15]) begin
        for (int i = 0; i < 4; i++) begin m_out[i] = 0; m_st[i] = 0; end
        m_ctl = 0; m_en = 0;
      end else begin
        for (int k = 0; k < 4; k++) begin
          logic [7:0] setb, clrb;
          setb = (m_en[k] ? rise[8*k +: 8] : 8'h0) | (m_en[k+4] ? fall[8*k +: 8] : 8'h0);
          clrb = wr[8+k] ? wb[8+k] : 8'h0;
          m_st[k] = (m_st[k] & ~clrb) | setb;
        end
        for (int b = 0; b < 4; b++) if (wr[b]) m_out[b] = wb[b];
        if (wr[12]) m_ctl = wb[12];
        if (wr[14]) m_en = wb[14];
      end
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = {pin_bd, pin_in};
    end
  end

  function automatic logic [7:0] m_rd(int b);
    case (b)
      0, 1, 2, 3:  return m_out[b];
      4, 5, 6:     return m_p2[8*(b-4) +: 8];
      7:           return m_ctl[1] ? m_out[3] : m_p2[31:24];
      8, 9, 10, 11: return m_st[b-8];
      12:          return m_ctl;
      14:          return m_en;
      default:     return 8'h0;
    endcase
  endfunction

  function automatic string req_of(int b);
    case (b)
      0, 1, 2:  return "R1";
      3, 12:    return "R2";
      4, 5, 6, 7: return "R3";
      8, 9, 10, 11: return "R9";
      14:       return "R5";
      default:  return "R10";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1", {8'h0, out_w}, {8'h0, m_out[2], m_out[1], m_out[0]});
    chk("R2", {31'h0, bd_oe}, {31'h0, m_ctl[1]});
    chk("R2", {24'h0, bd_o}, {24'h0, m_ctl[1] ? m_out[3] : 8'h0});
    chk("R8", {31'h0, irq}, {31'h0, |{m_st[0], m_st[1], m_st[2], m_st[3]}});
    for (int l = 0; l < 4; l++)
      chk(req_of(addr*4 + l), {24'h0, rdata[8*l +: 8]}, {24'h0, m_rd(addr*4 + l)});
  endtask

  task automatic step(bit w, logic [1:0] a, logic [3:0] e, logic [31:0] d);
    @(negedge clk);
    if (rst_n) compare_all();
    we = w; addr = a; be = e; wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 2'(i), 4'h0, 32'h0);
  endtask

  task automatic dchk(logic [1:0] a, logic [31:0] exp, string req);
    we = 0; addr = a; be = 0;
    #1;
    chk(req, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    for (int w = 0; w < 4; w++) dchk(2'(w), 32'h0, "R11");
    chk("R11", {7'h0, irq, bd_oe, bd_o, out_w[15:0]}, 32'h0);

    // R1 output bytes
    step(1, 0, 4'b0111, 32'h00A55A3C); idle(1);
    chk("R1", {8'h0, out_w}, 32'h00A55A3C);
    dchk(0, 32'h00A55A3C, "R1");
    // R9 byte enables
    step(1, 0, 4'b0010, 32'h1111FF11); idle(1);
    chk("R9", {8'h0, out_w}, 32'h00A5FF3C);

    // R2 latch gated by direction bit
    step(1, 0, 4'b1000, 32'h81000000); idle(1);
    chk("R2", {23'h0, bd_oe, bd_o}, 32'h0);
    step(1, 3, 4'b0001, 32'h00000002); idle(1);
    chk("R2", {23'h0, bd_oe, bd_o}, 32'h181);
    dchk(1, 32'h81000000, "R3");

    // R3 synchroniser latency and byte-7 source
    idle(1);
    pin_in = 24'h123456; pin_bd = 8'h5A;
    idle(1); dchk(1, 32'h81000000, "R3");
    idle(1); dchk(1, 32'h81123456, "R3");
    step(1, 3, 4'b0001, 32'h0); idle(2);
    dchk(1, 32'h5A123456, "R3");
    dchk(2, 32'h0, "R5");

    // R4 rising enable on bank 0, exact latency
    step(1, 3, 4'b0100, 32'h00010000); idle(1);
    pin_in = 24'h123457;
    idle(2); dchk(2, 32'h0, "R4");
    idle(1); dchk(2, 32'h00000001, "R4");
    chk("R8", {31'h0, irq}, 32'h1);
    pin_in = 24'h123456;
    idle(4); dchk(2, 32'h00000001, "R5");
    step(1, 3, 4'b0100, 32'h00810000); idle(1);
    pin_bd = 8'h58;
    idle(4); dchk(2, 32'h02000001, "R4");

    // R6 write-one-to-clear, R8 irq drop
    step(1, 2, 4'b1111, 32'h00000001); idle(1);
    dchk(2, 32'h02000000, "R6");
    chk("R8", {31'h0, irq}, 32'h1);
    step(1, 2, 4'b1111, 32'h02000000); idle(1);
    chk("R8", {31'h0, irq}, 32'h0);
    dchk(2, 32'h0, "R6");

    // R7 edge and clear in the same cycle
    idle(1);
    pin_in = 24'h123457;
    idle(1);
    step(1, 2, 4'b0001, 32'h00000001);
    idle(1);
    dchk(2, 32'h00000001, "R7");

    // R10 reserved byte and soft reset
    step(1, 3, 4'b0010, 32'h0000FF00); idle(1);
    dchk(3, 32'h00810000, "R10");
    step(1, 3, 4'b0001, 32'h00000002);
    step(1, 3, 4'b1000, 32'hFF000000); idle(1);
    chk("R10", {6'h0, irq, bd_oe, out_w}, 32'h0);
    dchk(0, 32'h0, "R10");
    dchk(2, 32'h0, "R10");
    dchk(3, 32'h0, "R10");

    // mixed traffic against the model
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = int'($urandom % 8);
      if (r < 3) begin
        logic [1:0] w;
        logic [3:0] e;
        w = 2'($urandom % 4);
        e = 4'($urandom);
        if (w == 3 && ($urandom % 16) != 0) e[3] = 1'b0;
        step(1, w, e, $urandom);
      end else begin
        step(0, 2'($urandom), 4'h0, 32'h0);
      end
      if ($urandom % 3 == 0) begin
        pin_in = pin_in ^ 24'($urandom & $urandom);
        pin_bd = pin_bd ^ 8'($urandom & $urandom);
      end
    end
    idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule